// File: doc/BRIEF.md
# Strappable Memory-Map Chip-Select Decoder

This block produces the chip selects and data-bus steering for a small 8-bit computer with a 16-bit address bus. It looks only at the six upper address bits (A15 down to A10), an active-low memory-cycle strobe and the active-low CPU read strobe. The first stage picks one 4K region from the upper hex digit, but only while the memory strobe is low and A15 is low, so only the lower 32K is decoded. Inside the 3xxx page the block uses A11 and A10 to tell the keyboard window apart from the video RAM window.

The ROM and RAM region lines each pass through a strap link. A link is either connected or broken, and this is set by a static parameter. A broken link leaves its select pulled high, which is how an unpopulated ROM or RAM bank is taken out of the map. The selects then drive three enables: a shared memory-buffer enable for ROM and RAM reads, and the two data-bus direction enables on the CPU side.

All outputs are combinational in the inputs. The clock and reset are used only by the embedded property checks.

Top module: `mmap_decoder`

## Requirements
- R1: While `mem_n` is high, or while `addr_hi[5]` (A15) is high, all four select outputs and all three enable outputs are high.
- R2: With `mem_n` low, `addr_hi[5:2]` = 4'h0 drives `rom_sel_n` low when the ROM link is connected.
- R3: With `mem_n` low, `addr_hi` = 6'b001110 (the 3800h window) drives `kbd_sel_n` low.
- R4: With `mem_n` low, `addr_hi` = 6'b001111 (the 3C00h window) drives `vid_sel_n` low. The keyboard select and the video select are never low together.
- R5: With `mem_n` low, `addr_hi[5:2]` = 4'h4 (4000h to 4FFFh) drives `ram_sel_n` low when the RAM link is connected.
- R6: At most one select is low at any time. Digits 1, 2, 5, 6 and 7, and the 3000h to 37FFh half of page 3, assert no select.
- R7: `LINK_MASK` bit 0 strap-connects ROM and bit 1 strap-connects RAM. When a bit is 0, the matching select stays high for every input.
- R8: `mem_buf_n` is low exactly when `rd_n` is low and either `rom_sel_n` or `ram_sel_n` is low.
- R9: `dbin_n` is low exactly when `mem_n` is low, `rd_n` is low and any select is low. This includes keyboard and video reads.
- R10: `dbout_n` is low exactly when `mem_n` is low, `rd_n` is high and any select is low. `dbin_n` and `dbout_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the embedded property checks |
| rst | input | 1 | Synchronous active-high reset; disables the checks |
| addr_hi | input | 6 | Address bits A15..A10; bit 5 is A15 |
| mem_n | input | 1 | Memory-cycle strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| rom_sel_n | output | 1 | ROM chip select, active low |
| kbd_sel_n | output | 1 | Keyboard buffer enable, active low |
| vid_sel_n | output | 1 | Video RAM select, active low |
| ram_sel_n | output | 1 | RAM chip select, active low |
| mem_buf_n | output | 1 | ROM/RAM data buffer enable, active low |
| dbin_n | output | 1 | CPU-side data input enable, active low |
| dbout_n | output | 1 | CPU-side data output enable, active low |

## Verification
A fixed table tries a set of representative inputs. The ROM, keyboard, video and RAM windows are each read once. The RAM and keyboard windows are also tried with the read strobe high, which separates the read direction from the write direction. The table also hits the 3000h and 3400h holes, digit 1, and addresses above 8000h, which separates the A11/A10 sub-decode from the plain top-digit decode.

After the table comes a full sweep of all 64 upper-address values under all four combinations of strobe and read. The sweep runs one instance with both links connected and a second instance with both links broken. Comparing the two instances isolates the effect of the straps.

// File: rtl/mmap_dec_pkg.sv
package mmap_dec_pkg;

    // Upper address slice carried into the block: A15..A10
    localparam int ADDR_HI_W = 6;
    localparam int DIGIT_W   = 4;

    // Region digits that the first stage must recognise
    localparam logic [DIGIT_W-1:0] DIGIT_ROM  = 4'h0;
    localparam logic [DIGIT_W-1:0] DIGIT_PAGE = 4'h3;
    localparam logic [DIGIT_W-1:0] DIGIT_RAM  = 4'h4;

    // Line order on the first-stage bus
    localparam int LINE_ROM  = 0;
    localparam int LINE_PAGE = 1;
    localparam int LINE_RAM  = 2;
    localparam int NUM_LINES = 3;

    // Strap bit positions
    localparam int LINK_ROM  = 0;
    localparam int LINK_RAM  = 1;
    localparam int NUM_LINKS = 2;

    typedef struct packed {
        logic rom_n;
        logic kbd_n;
        logic vid_n;
        logic ram_n;
    } sel_t;

    typedef struct packed {
        logic mem_buf_n;
        logic dbin_n;
        logic dbout_n;
    } steer_t;

    function automatic logic [DIGIT_W-1:0] top_digit(input logic [ADDR_HI_W-1:0] a);
        return a[ADDR_HI_W-1 -: DIGIT_W];
    endfunction

    function automatic logic any_selected(input sel_t s);
        return !(s.rom_n & s.kbd_n & s.vid_n & s.ram_n);
    endfunction

endpackage

// File: rtl/region_decoder.sv
module region_decoder
    import mmap_dec_pkg::*;
#(
    parameter int                     N      = NUM_LINES,
    parameter logic [N*DIGIT_W-1:0]   DIGITS = {DIGIT_RAM, DIGIT_PAGE, DIGIT_ROM}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic                 mem_n,
    output logic [N-1:0]         line_n
);

    logic stage_en;
    assign stage_en = !mem_n && !addr_hi[ADDR_HI_W-1];

    for (genvar i = 0; i < N; i++) begin : g_line
        assign line_n[i] = !(stage_en && (top_digit(addr_hi) == DIGITS[i*DIGIT_W +: DIGIT_W]));

        // R1: a region line is only active inside a memory cycle
        a_r1_line_needs_strobe: assert property (@(posedge clk) disable iff (rst)
            !line_n[i] |-> !mem_n);
    end

    // R6: the first-stage lines are mutually exclusive
    a_r6_lines_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones(~line_n) <= 1);

endmodule

// File: rtl/link_bank.sv
module link_bank #(
    parameter int           N    = 2,
    parameter logic [N-1:0] MASK = '1
) (
    input  logic [N-1:0] in_n,
    output logic [N-1:0] out_n
);

    for (genvar i = 0; i < N; i++) begin : g_link
        if (MASK[i]) begin : g_made
            assign out_n[i] = in_n[i];
        end else begin : g_cut
            // a broken strap floats to the pull-up level
            assign out_n[i] = 1'b1;
        end
    end

endmodule

// File: rtl/page_split.sv
module page_split (
    input  logic clk,
    input  logic rst,
    input  logic page_n,
    input  logic a11,
    input  logic a10,
    output logic kbd_n,
    output logic vid_n
);

    logic upper_half;
    assign upper_half = !page_n && a11;

    assign kbd_n = !(upper_half && !a10);
    assign vid_n = !(upper_half &&  a10);

    // R4: keyboard and video windows never overlap
    a_r4_kbd_vid_apart: assert property (@(posedge clk) disable iff (rst)
        !(!kbd_n && !vid_n));

    // R3: keyboard only inside the page-3 line
    a_r3_kbd_in_page: assert property (@(posedge clk) disable iff (rst)
        !kbd_n |-> !page_n);

endmodule

// File: rtl/bus_steer.sv
module bus_steer
    import mmap_dec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sel_t   sel,
    input  logic   mem_n,
    input  logic   rd_n,
    output steer_t steer
);

    logic hit;
    logic store_hit;

    assign hit       = any_selected(sel);
    assign store_hit = !sel.rom_n || !sel.ram_n;

    always_comb begin
        steer.mem_buf_n = !(!rd_n && store_hit);
        steer.dbin_n    = !(!mem_n && !rd_n && hit);
        steer.dbout_n   = !(!mem_n &&  rd_n && hit);
    end

    // R10: the two direction enables are exclusive
    a_r10_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!steer.dbin_n && !steer.dbout_n));

    // R8: buffer enable only during a read
    a_r8_buf_on_read: assert property (@(posedge clk) disable iff (rst)
        !steer.mem_buf_n |-> !rd_n);

    // R9: input direction needs a live strobe
    a_r9_dbin_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !steer.dbin_n |-> (!mem_n && !rd_n));

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_dec_pkg::*;
#(
    parameter logic [NUM_LINKS-1:0] LINK_MASK = 2'b11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic                 mem_n,
    input  logic                 rd_n,
    output logic                 rom_sel_n,
    output logic                 kbd_sel_n,
    output logic                 vid_sel_n,
    output logic                 ram_sel_n,
    output logic                 mem_buf_n,
    output logic                 dbin_n,
    output logic                 dbout_n
);

    logic [NUM_LINES-1:0] line_n;
    logic [NUM_LINKS-1:0] strap_in_n;
    logic [NUM_LINKS-1:0] strap_out_n;
    logic                 kbd_n;
    logic                 vid_n;
    sel_t                 sel;
    steer_t               steer;

    region_decoder #(
        .N      (NUM_LINES),
        .DIGITS ({DIGIT_RAM, DIGIT_PAGE, DIGIT_ROM})
    ) u_region (
        .clk     (clk),
        .rst     (rst),
        .addr_hi (addr_hi),
        .mem_n   (mem_n),
        .line_n  (line_n)
    );

    always_comb begin
        strap_in_n           = '1;
        strap_in_n[LINK_ROM] = line_n[LINE_ROM];
        strap_in_n[LINK_RAM] = line_n[LINE_RAM];
    end

    link_bank #(
        .N    (NUM_LINKS),
        .MASK (LINK_MASK)
    ) u_links (
        .in_n  (strap_in_n),
        .out_n (strap_out_n)
    );

    page_split u_page (
        .clk    (clk),
        .rst    (rst),
        .page_n (line_n[LINE_PAGE]),
        .a11    (addr_hi[1]),
        .a10    (addr_hi[0]),
        .kbd_n  (kbd_n),
        .vid_n  (vid_n)
    );

    always_comb begin
        sel.rom_n = strap_out_n[LINK_ROM];
        sel.kbd_n = kbd_n;
        sel.vid_n = vid_n;
        sel.ram_n = strap_out_n[LINK_RAM];
    end

    bus_steer u_steer (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .mem_n (mem_n),
        .rd_n  (rd_n),
        .steer (steer)
    );

    assign rom_sel_n = sel.rom_n;
    assign kbd_sel_n = sel.kbd_n;
    assign vid_sel_n = sel.vid_n;
    assign ram_sel_n = sel.ram_n;
    assign mem_buf_n = steer.mem_buf_n;
    assign dbin_n    = steer.dbin_n;
    assign dbout_n   = steer.dbout_n;

    // R1: outside the decoded space everything idles high
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (mem_n || addr_hi[ADDR_HI_W-1]) |->
        (&{rom_sel_n, kbd_sel_n, vid_sel_n, ram_sel_n, mem_buf_n, dbin_n, dbout_n}));

    // R6: at most one select at the pins
    a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~{rom_sel_n, kbd_sel_n, vid_sel_n, ram_sel_n}) <= 1);

    // R2: ROM select tracks digit 0
    a_r2_rom_digit: assert property (@(posedge clk) disable iff (rst)
        !rom_sel_n |-> (addr_hi[5:2] == DIGIT_ROM));

    // R5: RAM select tracks digit 4
    a_r5_ram_digit: assert property (@(posedge clk) disable iff (rst)
        !ram_sel_n |-> (addr_hi[5:2] == DIGIT_RAM));

endmodule

// File: tb/mmap_decoder_test.sv
module mmap_decoder_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] addr_hi;
    logic       mem_n;
    logic       rd_n;
    logic [6:0] act_a, act_b;
    int         n_run  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #4 clk = ~clk;

    // uut: both straps made; uut_cut: both straps broken
    mmap_decoder #(.LINK_MASK(2'b11)) uut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .mem_n(mem_n), .rd_n(rd_n),
        .rom_sel_n(act_a[6]), .kbd_sel_n(act_a[5]), .vid_sel_n(act_a[4]),
        .ram_sel_n(act_a[3]), .mem_buf_n(act_a[2]), .dbin_n(act_a[1]),
        .dbout_n(act_a[0]));

    mmap_decoder #(.LINK_MASK(2'b00)) uut_cut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .mem_n(mem_n), .rd_n(rd_n),
        .rom_sel_n(act_b[6]), .kbd_sel_n(act_b[5]), .vid_sel_n(act_b[4]),
        .ram_sel_n(act_b[3]), .mem_buf_n(act_b[2]), .dbin_n(act_b[1]),
        .dbout_n(act_b[0]));

    // Expected {rom,kbd,vid,ram,buf,dbin,dbout}, built from the requirements
    function automatic logic [6:0] model(input logic [5:0] a, input logic m,
                                         input logic r, input logic [1:0] mask);
        logic en, rom, kbd, vid, ram, any;
        en  = !m && !a[5];
        rom = !(en && a[5:2] == 4'h0 && mask[0]);
        kbd = !(en && a[5:2] == 4'h3 && a[1] && !a[0]);
        vid = !(en && a[5:2] == 4'h3 && a[1] &&  a[0]);
        ram = !(en && a[5:2] == 4'h4 && mask[1]);
        any = !(rom && kbd && vid && ram);
        return {rom, kbd, vid, ram, !(!r && (!rom || !ram)), !(!m && !r && any),
                !(!m && r && any)};
    endfunction

    // {addr_hi, mem_n, rd_n, expected}
    localparam logic [14:0] VEC [12] = '{
        {6'b000000, 1'b0, 1'b0, 7'b0111_001},  // R2 ROM read
        {6'b001110, 1'b0, 1'b0, 7'b1011_101},  // R3 keyboard read
        {6'b001111, 1'b0, 1'b0, 7'b1101_101},  // R4 video read
        {6'b010000, 1'b0, 1'b0, 7'b1110_001},  // R5 RAM read
        {6'b010011, 1'b0, 1'b1, 7'b1110_110},  // R10 RAM write
        {6'b000000, 1'b1, 1'b0, 7'b1111_111},  // R1 strobe idle
        {6'b100000, 1'b0, 1'b0, 7'b1111_111},  // R1 A15 high
        {6'b001100, 1'b0, 1'b0, 7'b1111_111},  // R6 3000h hole
        {6'b001101, 1'b0, 1'b0, 7'b1111_111},  // R6 3400h hole
        {6'b000111, 1'b0, 1'b0, 7'b1111_111},  // R6 digit 1
        {6'b001110, 1'b0, 1'b1, 7'b1011_110},  // R9 R10 keyboard non-read
        {6'b110000, 1'b0, 1'b0, 7'b1111_111}   // R1 upper space
    };

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr_hi=%b mem_n=%b rd_n=%b actual=%b expected=%b",
                     req, addr_hi, mem_n, rd_n, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] a, input logic m, input logic r);
        @(negedge clk);
        addr_hi = a;
        mem_n   = m;
        rd_n    = r;
        #2;
    endtask

    initial begin
        addr_hi = '0;
        mem_n   = 1'b1;
        rd_n    = 1'b1;
        rst     = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset idle", act_a, 7'b1111_111);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < 12; i++) begin
            apply(VEC[i][14:9], VEC[i][8], VEC[i][7]);
            check("R1/R2/R3/R4/R5/R6/R9/R10 table", act_a, VEC[i][6:0]);
        end

        // directed: broken straps keep ROM and RAM quiet (R7)
        apply(6'b000000, 1'b0, 1'b0);
        check("R7 ROM strap cut", act_b, 7'b1111_111);
        apply(6'b010001, 1'b0, 1'b0);
        check("R7 RAM strap cut", act_b, 7'b1111_111);
        apply(6'b001110, 1'b0, 1'b0);
        check("R7 keyboard unaffected by straps", act_b, 7'b1011_101);

        // full sweep
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 2; r++) begin
                for (int a = 0; a < 64; a++) begin
                    apply(6'(a), 1'(m), 1'(r));
                    check("R1..R10 sweep straps made", act_a, model(6'(a), 1'(m), 1'(r), 2'b11));
                    check("R7 sweep straps cut", act_b, model(6'(a), 1'(m), 1'(r), 2'b00));
                    n_run++;
                    if ($countones(~act_a[6:3]) > 1) begin
                        n_fail++;
                        $display("FAIL R6 multiple selects actual=%b expected=at most one low",
                                 act_a[6:3]);
                    end
                end
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule